// File: doc/BRIEF.md
# Interleaved Address Target Selector

This block takes a host physical address and works out which downstream port should receive it. Its inputs are the fields of a small bank of address decoders. Each decoder has a 64-bit window, a control word and a list of eight port numbers, one per byte. The capability count sets how many decoders take part. The decoders are checked from index 0 upwards, and the first one whose window holds the address decides the result. If that decoder has not been committed, the lookup fails. Otherwise the address is cut into granules of a power-of-two size, and the granule number, taken modulo the number of ways, picks one port number from the decoder's list.

A lookup is a one-cycle strobe carrying an address. The registered result comes back on the next cycle as a valid strobe, a found flag and an 8-bit port number. A routing fabric uses the port number to steer the memory request. If the found flag is low, the request has no route.

Top module: `hdm_target_selector`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `res_valid_o`, `res_found_o` and `res_port_o` are all zero.
- R2: The result of a lookup appears exactly one clock cycle after the cycle in which `lkp_valid_i` is high. On a cycle that follows no lookup, `res_valid_o`, `res_found_o` and `res_port_o` are zero.
- R3: The count field `cap_count_i` sets how many decoders are scanned, starting at index 0. The codes are: 0→1; codes 1 to 8 give twice the code (2, 4, … 16); 9→20, 10→24, 11→28, 12→32. Any other code means no decoder, so every lookup is not found. A count larger than NUM_DEC is cut down to NUM_DEC.
- R4: A decoder's base is {base_hi, base_lo[31:28], 28'b0}, and its size is built the same way from its size words. The decoder matches when base ≤ address < base + size, with the sum taken without wrap-around. Bits 27:0 of the low words are ignored.
- R5: Among the decoders that are scanned, the lowest-index match is the only one used. Higher-index matches are ignored.
- R6: If the first matching decoder has its committed bit (control bit 10) clear, the lookup reports not found. No later decoder is tried.
- R7: If no scanned decoder matches, the lookup reports not found. On any lookup that is not found, `res_port_o` is zero.
- R8: The way index is (address >> (g + 8)) masked to its low w bits. Here g is control bits 3:0 and w is control bits 7:4. This gives a granule of 2^(g+8) bytes and 2^w ways.
- R9: A way index i below 4 selects bits [8i+7:8i] of the decoder's low target word. An index of 4 or more selects bits [8(i−4)+7:8(i−4)] of the high target word.
- R10: If the chosen decoder has w greater than 3, the lookup reports not found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid_i | input | 1 | Lookup strobe |
| lkp_addr_i | input | 64 | Host physical address to route |
| cap_count_i | input | 4 | Encoded decoder count |
| dec_base_lo_i | input | NUM_DEC*32 | Low base word per decoder (decoder i at bits 32i+31:32i) |
| dec_base_hi_i | input | NUM_DEC*32 | High base word per decoder |
| dec_size_lo_i | input | NUM_DEC*32 | Low size word per decoder |
| dec_size_hi_i | input | NUM_DEC*32 | High size word per decoder |
| dec_ctrl_i | input | NUM_DEC*32 | Control word per decoder (granule, ways, committed) |
| dec_tgt_lo_i | input | NUM_DEC*32 | Port numbers for way indices 0 to 3 |
| dec_tgt_hi_i | input | NUM_DEC*32 | Port numbers for way indices 4 to 7 |
| res_valid_o | output | 1 | Result strobe, one cycle after the lookup |
| res_found_o | output | 1 | A committed decoder routed the address |
| res_port_o | output | 8 | Selected downstream port number |

## Verification
Every result is registered once. It is due on the cycle after the edge that captures the lookup strobe, and it holds for exactly that one cycle. The bench drives the address and strobe on a falling edge and lets one rising edge pass. It reads the outputs on the falling edge that follows, so each check sees the result of that one lookup and nothing earlier. The idle check uses the same spacing with the strobe low, and confirms that nothing leaks into the following cycle.

// File: rtl/hdm_sel_pkg.sv
package hdm_sel_pkg;

    localparam int ADDR_W      = 64;
    localparam int WORD_W      = 32;
    localparam int PORT_W      = 8;
    localparam int COUNT_W     = 6;
    localparam int COMMIT_BIT  = 10;
    localparam int GRAN_LSB    = 0;
    localparam int WAYS_LSB    = 4;
    localparam int GRAN_BASE   = 8;
    localparam logic [WORD_W-1:0] LO_KEEP = 32'hF000_0000;

    typedef struct packed {
        logic              valid;
        logic              found;
        logic [PORT_W-1:0] port;
    } sel_res_t;

    // Encoded decoder count to number of decoders; unknown codes give zero.
    function automatic logic [COUNT_W-1:0] count_decode(input logic [3:0] enc);
        logic [COUNT_W-1:0] n;
        if (enc == 4'd0)
            n = 6'd1;
        else if (enc <= 4'd8)
            n = {1'b0, enc, 1'b0};
        else if (enc <= 4'd12)
            n = 6'd20 + {enc - 4'd9, 2'b00};
        else
            n = 6'd0;
        return n;
    endfunction

endpackage

// File: rtl/hdm_window_match.sv
module hdm_window_match
    import hdm_sel_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] base_lo_i,
    input  logic [WORD_W-1:0] base_hi_i,
    input  logic [WORD_W-1:0] size_lo_i,
    input  logic [WORD_W-1:0] size_hi_i,
    output logic              hit_o
);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] size;
    logic [ADDR_W:0]   limit;

    always_comb begin
        base  = {base_hi_i, base_lo_i & LO_KEEP};
        size  = {size_hi_i, size_lo_i & LO_KEEP};
        limit = {1'b0, base} + {1'b0, size};
        hit_o = (addr_i >= base) && ({1'b0, addr_i} < limit);
    end

endmodule

// File: rtl/hdm_way_pick.sv
module hdm_way_pick
    import hdm_sel_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        gran_i,
    input  logic [3:0]        ways_i,
    input  logic [WORD_W-1:0] tgt_lo_i,
    input  logic [WORD_W-1:0] tgt_hi_i,
    output logic              ok_o,
    output logic [PORT_W-1:0] port_o
);

    logic [4:0] shamt;
    logic [2:0] granule;
    logic [2:0] mask;
    logic [2:0] way;

    always_comb begin
        shamt   = {1'b0, gran_i} + 5'(GRAN_BASE);
        granule = 3'(addr_i >> shamt);
        mask    = 3'((4'd1 << ways_i[1:0]) - 4'd1);
        way     = granule & mask;
        ok_o    = (ways_i <= 4'd3);
        if (!way[2])
            port_o = tgt_lo_i[{way[1:0], 3'b000} +: PORT_W];
        else
            port_o = tgt_hi_i[{way[1:0], 3'b000} +: PORT_W];
    end

endmodule

// File: rtl/hdm_target_selector.sv
module hdm_target_selector
    import hdm_sel_pkg::*;
#(
    parameter int NUM_DEC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lkp_valid_i,
    input  logic [63:0]             lkp_addr_i,
    input  logic [3:0]              cap_count_i,
    input  logic [NUM_DEC*32-1:0]   dec_base_lo_i,
    input  logic [NUM_DEC*32-1:0]   dec_base_hi_i,
    input  logic [NUM_DEC*32-1:0]   dec_size_lo_i,
    input  logic [NUM_DEC*32-1:0]   dec_size_hi_i,
    input  logic [NUM_DEC*32-1:0]   dec_ctrl_i,
    input  logic [NUM_DEC*32-1:0]   dec_tgt_lo_i,
    input  logic [NUM_DEC*32-1:0]   dec_tgt_hi_i,
    output logic                    res_valid_o,
    output logic                    res_found_o,
    output logic [7:0]              res_port_o
);

    localparam int IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1;

    logic [COUNT_W-1:0] scan_n;
    logic [NUM_DEC-1:0] hit;
    logic [NUM_DEC-1:0] in_scope;
    logic               any_hit;
    logic [IDX_W-1:0]   sel_idx;
    logic [WORD_W-1:0]  sel_ctrl;
    logic [WORD_W-1:0]  sel_tgt_lo;
    logic [WORD_W-1:0]  sel_tgt_hi;
    logic               pick_ok;
    logic [PORT_W-1:0]  pick_port;
    sel_res_t           res_d;
    sel_res_t           res_q;

    assign scan_n = count_decode(cap_count_i);

    for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
        hdm_window_match u_win (
            .addr_i    (lkp_addr_i),
            .base_lo_i (dec_base_lo_i[g*WORD_W +: WORD_W]),
            .base_hi_i (dec_base_hi_i[g*WORD_W +: WORD_W]),
            .size_lo_i (dec_size_lo_i[g*WORD_W +: WORD_W]),
            .size_hi_i (dec_size_hi_i[g*WORD_W +: WORD_W]),
            .hit_o     (hit[g])
        );
        assign in_scope[g] = (COUNT_W'(g) < scan_n);
    end

    // Lowest in-scope index wins.
    always_comb begin
        any_hit = 1'b0;
        sel_idx = '0;
        for (int i = NUM_DEC - 1; i >= 0; i--) begin
            if (hit[i] && in_scope[i]) begin
                any_hit = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
        sel_ctrl   = dec_ctrl_i[sel_idx*WORD_W +: WORD_W];
        sel_tgt_lo = dec_tgt_lo_i[sel_idx*WORD_W +: WORD_W];
        sel_tgt_hi = dec_tgt_hi_i[sel_idx*WORD_W +: WORD_W];
    end

    hdm_way_pick u_pick (
        .addr_i   (lkp_addr_i),
        .gran_i   (sel_ctrl[GRAN_LSB +: 4]),
        .ways_i   (sel_ctrl[WAYS_LSB +: 4]),
        .tgt_lo_i (sel_tgt_lo),
        .tgt_hi_i (sel_tgt_hi),
        .ok_o     (pick_ok),
        .port_o   (pick_port)
    );

    always_comb begin
        res_d = '0;
        if (lkp_valid_i) begin
            res_d.valid = 1'b1;
            if (any_hit && sel_ctrl[COMMIT_BIT] && pick_ok) begin
                res_d.found = 1'b1;
                res_d.port  = pick_port;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign res_valid_o = res_q.valid;
    assign res_found_o = res_q.found;
    assign res_port_o  = res_q.port;

endmodule

// File: rtl/hdm_target_selector_chk.sv
module hdm_target_selector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lkp_valid_i,
    input logic [3:0] cap_count_i,
    input logic       res_valid_o,
    input logic       res_found_o,
    input logic [7:0] res_port_o
);

    assert_result_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid_i |=> res_valid_o);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid_i |=> (!res_valid_o && !res_found_o && res_port_o == 8'h00));

    assert_bad_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid_i && cap_count_i > 4'hC) |=> !res_found_o);

    assert_miss_port_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_found_o) |-> res_port_o == 8'h00);

    assert_found_has_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_found_o |-> res_valid_o);

endmodule

bind hdm_target_selector hdm_target_selector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lkp_valid_i (lkp_valid_i),
    .cap_count_i (cap_count_i),
    .res_valid_o (res_valid_o),
    .res_found_o (res_found_o),
    .res_port_o  (res_port_o)
);

// File: tb/hdm_target_selector_tb.sv
`timescale 1ns/1ps
module hdm_target_selector_tb;

    localparam int ND = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lkp_valid_i = 1'b0;
    logic [63:0]      lkp_addr_i = '0;
    logic [3:0]       cap_count_i = 4'd2;
    logic [ND*32-1:0] base_lo = '0, base_hi = '0, size_lo = '0, size_hi = '0;
    logic [ND*32-1:0] ctrl = '0, tgt_lo = '0, tgt_hi = '0;
    logic             res_valid_o, res_found_o;
    logic [7:0]       res_port_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    hdm_target_selector #(.NUM_DEC(ND)) u_dut (
        .clk(clk), .rst_n(rst_n), .lkp_valid_i(lkp_valid_i), .lkp_addr_i(lkp_addr_i),
        .cap_count_i(cap_count_i), .dec_base_lo_i(base_lo), .dec_base_hi_i(base_hi),
        .dec_size_lo_i(size_lo), .dec_size_hi_i(size_hi), .dec_ctrl_i(ctrl),
        .dec_tgt_lo_i(tgt_lo), .dec_tgt_hi_i(tgt_hi),
        .res_valid_o(res_valid_o), .res_found_o(res_found_o), .res_port_o(res_port_o)
    );

    task automatic set_dec(input int i, input logic [63:0] base, input logic [63:0] size,
                           input logic [31:0] c, input logic [31:0] tl, input logic [31:0] th);
        base_lo[i*32 +: 32] = base[31:0];
        base_hi[i*32 +: 32] = base[63:32];
        size_lo[i*32 +: 32] = size[31:0];
        size_hi[i*32 +: 32] = size[63:32];
        ctrl[i*32 +: 32]    = c;
        tgt_lo[i*32 +: 32]  = tl;
        tgt_hi[i*32 +: 32]  = th;
    endtask

    task automatic check(input string req, input logic v, input logic f, input logic [7:0] p);
        total++;
        if (res_valid_o !== v || res_found_o !== f || res_port_o !== p) begin
            bad++;
            $display("FAIL %s: got valid=%0b found=%0b port=%02h, expected valid=%0b found=%0b port=%02h",
                     req, res_valid_o, res_found_o, res_port_o, v, f, p);
        end
    endtask

    // Drive on a falling edge, one rising edge captures, sample on the next falling edge.
    task automatic lookup(input string req, input logic [63:0] a, input logic f, input logic [7:0] p);
        @(negedge clk);
        lkp_addr_i  = a;
        lkp_valid_i = 1'b1;
        @(negedge clk);
        lkp_valid_i = 1'b0;
        check(req, 1'b1, f, p);
    endtask

    task automatic setup_default();
        cap_count_i = 4'd2;
        set_dec(0, 64'h1_0000_0000, 64'h1000_0000, 32'h420, 32'h4433_2211, 32'h8877_6655);
        set_dec(1, 64'h1_1000_0000, 64'h2000_0000, 32'h434, 32'hA3A2_A1A0, 32'hA7A6_A5A4);
        set_dec(2, 64'h2_0000_0000, 64'h1000_0000, 32'h000, 32'hB3B2_B1B0, 32'hB7B6_B5B4);
        set_dec(3, 64'h2_0000_0000, 64'h1000_0000, 32'h400, 32'hC3C2_C1F0, 32'hC7C6_C5C4);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 in reset", 1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_idle();
        @(negedge clk);
        lkp_addr_i  = 64'h1_0000_0000;
        lkp_valid_i = 1'b0;
        @(negedge clk);
        check("R2 idle cycle", 1'b0, 1'b0, 8'h00);
        lookup("R2 lookup one cycle", 64'h1_0000_0100, 1'b1, 8'h22);
        @(negedge clk);
        check("R2 strobe lasts one cycle", 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_interleave();
        lookup("R8 way0 g256", 64'h1_0000_0000, 1'b1, 8'h11);
        lookup("R8 way3 g256", 64'h1_0000_0300, 1'b1, 8'h44);
        lookup("R8 modulo wrap", 64'h1_0000_0400, 1'b1, 8'h11);
        lookup("R8 inside granule", 64'h1_1000_0FFF, 1'b1, 8'hA0);
        lookup("R9 way5 high word", 64'h1_1000_5000, 1'b1, 8'hA5);
        lookup("R9 way7 high word", 64'h1_1000_7000, 1'b1, 8'hA7);
        lookup("R9 way4 high word", 64'h1_1000_4000, 1'b1, 8'hA4);
        lookup("R8 eight-way wrap", 64'h1_1000_8000, 1'b1, 8'hA0);
    endtask

    task automatic t_window();
        lookup("R4 last byte of window", 64'h1_0FFF_FFFF, 1'b1, 8'h44);
        lookup("R7 end of window excluded", 64'h1_3000_0000, 1'b0, 8'h00);
        lookup("R7 below all windows", 64'h0_0FFF_FFFF, 1'b0, 8'h00);
        base_lo[31:0] = 32'h0FFF_FFFF;
        lookup("R4 low base bits ignored", 64'h1_0000_0000, 1'b1, 8'h11);
        base_lo[31:0] = 32'h0000_0000;
    endtask

    task automatic t_priority();
        set_dec(1, 64'h1_0000_0000, 64'h2000_0000, 32'h434, 32'hA3A2_A1A0, 32'hA7A6_A5A4);
        lookup("R5 lowest index wins", 64'h1_0000_0000, 1'b1, 8'h11);
        setup_default();
        lookup("R6 uncommitted first match", 64'h2_0000_0000, 1'b0, 8'h00);
        set_dec(2, 64'h3_0000_0000, 64'h1000_0000, 32'h000, 32'hB3B2_B1B0, 32'hB7B6_B5B4);
        lookup("R6 committed later decoder", 64'h2_0000_0000, 1'b1, 8'hF0);
    endtask

    task automatic t_count();
        cap_count_i = 4'd1;
        lookup("R3 two decoders skip idx3", 64'h2_0000_0000, 1'b0, 8'h00);
        cap_count_i = 4'hD;
        lookup("R3 undefined code", 64'h1_0000_0000, 1'b0, 8'h00);
        cap_count_i = 4'hC;
        lookup("R3 count capped", 64'h2_0000_0000, 1'b1, 8'hF0);
        cap_count_i = 4'd0;
        lookup("R3 single decoder", 64'h1_0000_0100, 1'b1, 8'h22);
        lookup("R3 single decoder skip idx1", 64'h1_1000_0000, 1'b0, 8'h00);
        cap_count_i = 4'd2;
    endtask

    task automatic t_ways();
        ctrl[31:0] = 32'h440;
        lookup("R10 ways code 4", 64'h1_0000_0000, 1'b0, 8'h00);
        ctrl[31:0] = 32'h402;
        lookup("R8 g1024 one way", 64'h1_0000_0C00, 1'b1, 8'h11);
        ctrl[31:0] = 32'h412;
        lookup("R8 g1024 two way", 64'h1_0000_0C00, 1'b1, 8'h22);
        ctrl[31:0] = 32'h420;
    endtask

    initial begin
        setup_default();
        t_reset();
        t_idle();
        t_interleave();
        t_window();
        t_priority();
        t_count();
        t_ways();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule